// File: doc/BRIEF.md
# Prescaled 8-bit PWM Generator

This block drives one pulse-width-modulated output. A single 32-bit control word sets it up. The word carries a run flag, an 8-bit pre-divider value and an 8-bit low-phase length.

The input clock first passes through a prescaler. The prescaler divides by the pre-divider value, where a value of zero means a divide by 256. Each prescaler tick advances an 8-bit phase counter, so one frame is 256 phase steps long. The output is held low while the phase is below the low-phase length and is high for the rest of the frame. A low-phase length of zero parks the output low.

Software writes the word through a plain write port and can read it back at any time. Changes made while the generator runs are taken up at the next frame boundary, so a frame is never cut short or stretched.

Top module: `pwm8_prescaled`

## Requirements
- R1: The control word has the run flag in bit 31, the pre-divider in bits 15:8 and the low-phase length in bits 7:0. The readback returns these three fields as last written, and bits 30:16 always read as zero whatever was written to them.
- R2: While the synchronous active-high reset is asserted, the control word clears to zero and the output is low.
- R3: While running, the phase advances once every N input clocks, where N is the pre-divider value for values 1 to 255 and N is 256 for a pre-divider of 0.
- R4: A frame is 256 phase steps, so the output pattern repeats every 256 × N input clocks.
- R5: For a low-phase length D from 1 to 255, the output is low at phases 0 to D−1 and high at phases D to 255. This gives D low steps for every 256−D high steps.
- R6: With a low-phase length of 0 the output stays low for the whole time the generator runs.
- R7: A write that changes the pre-divider or the low-phase length while running does not alter the frame in progress. The new values govern every frame from the next frame boundary on. A write presented in the last input clock of a frame applies to the frame that follows it.
- R8: The first clock edge that captures a control word with bit 31 clear forces the output low from then on. The same edge returns the prescaler and the phase counter to zero.
- R9: The first clock edge that captures a word with bit 31 set starts a frame at phase 0 in its low phase. That frame uses the pre-divider and low-phase length carried in the enabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to be written |
| rd_data | output | 32 | Readback of the control word |
| pwm_out | output | 1 | PWM output |

## Verification
Two events can fall in the same clock: a software write and the frame-boundary reload of the working pre-divider and low-phase length. The bench provokes this by presenting a new low-phase length in the last input clock of a frame. It then checks that the very next frame already follows the new value. A separate scenario places a write in the middle of a frame and checks that the rest of that frame keeps the old shape. Expected waveforms are computed from the requirement formulas as functions of the cycle count since the enabling write.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CW     = 32;
    localparam int FW     = 8;
    localparam int RSV_W  = CW - 1 - 2 * FW;
    localparam int STEPS  = 1 << FW;

    typedef struct packed {
        logic          en;
        logic [FW-1:0] reload;
        logic [FW-1:0] duty;
    } ctrl_t;

    typedef struct packed {
        logic [FW-1:0] reload;
        logic [FW-1:0] duty;
    } wave_t;

    function automatic ctrl_t word_to_ctrl(input logic [CW-1:0] w);
        ctrl_t c;
        c.en     = w[CW-1];
        c.reload = w[2*FW-1:FW];
        c.duty   = w[FW-1:0];
        return c;
    endfunction

    function automatic logic [CW-1:0] ctrl_to_word(input ctrl_t c);
        return {c.en, {RSV_W{1'b0}}, c.reload, c.duty};
    endfunction

    function automatic logic [FW:0] divisor_of(input logic [FW-1:0] r);
        return (r == '0) ? (FW+1)'(STEPS) : {1'b0, r};
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
#(
    parameter int W = FW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] reload,
    output logic         tick
);
    localparam int CNT_W = W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] div;

    always_comb begin
        div  = (reload == '0) ? CNT_W'(1 << W) : {1'b0, reload};
        tick = run && (cnt == div - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + CNT_W'(1);
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt < div);
    assert_tick_restart_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));

endmodule

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr
    import pwm_pkg::*;
#(
    parameter int W = FW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    output logic [W-1:0] phase,
    output logic         wrap
);
    assign wrap = tick && (phase == '1);

    always_ff @(posedge clk) begin
        if (rst || !run) phase <= '0;
        else if (tick)   phase <= phase + W'(1);
    end

    assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (phase == '0));
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase == '0));

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
    import pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  wave_t nxt,
    output wave_t act
);
    always_ff @(posedge clk) begin
        if (rst)       act <= '0;
        else if (load) act <= nxt;
    end

endmodule

// File: rtl/pwm8_prescaled.sv
module pwm8_prescaled
    import pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    ctrl_t         ctrl, ctrl_nxt;
    wave_t         wave_nxt, wave_act;
    logic          tick, wrap, load;
    logic [FW-1:0] phase;

    always_comb begin
        ctrl_nxt        = wr_en ? word_to_ctrl(wr_data) : ctrl;
        wave_nxt.reload = ctrl_nxt.reload;
        wave_nxt.duty   = ctrl_nxt.duty;
        load            = !ctrl.en || wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl <= '0;
        else     ctrl <= ctrl_nxt;
    end

    assign rd_data = ctrl_to_word(ctrl);

    pwm_shadow u_shadow (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .nxt  (wave_nxt),
        .act  (wave_act)
    );

    pwm_prescaler #(.W(FW)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl.en),
        .reload (wave_act.reload),
        .tick   (tick)
    );

    pwm_phase_ctr #(.W(FW)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl.en),
        .tick  (tick),
        .phase (phase),
        .wrap  (wrap)
    );

    assign pwm_out = ctrl.en && (wave_act.duty != '0) && (phase >= wave_act.duty);

    assert_off_low_R8: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |-> !pwm_out);
    assert_duty_zero_low_R6: assert property (@(posedge clk) disable iff (rst)
        (wave_act.duty == '0) |-> !pwm_out);
    assert_frame_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && !wrap) |=> $stable(wave_act));
    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        rd_data[30:16] == '0);
    assert_reset_low_R2: assert property (@(posedge clk)
        rst |=> (!pwm_out && rd_data == '0));

endmodule

// File: tb/pwm8_prescaled_tb.sv
module pwm8_prescaled_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    pwm8_prescaled u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 'h%0h expected 'h%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_level(input int k, input int rl, input int d);
        int div;
        div = (rl == 0) ? 256 : rl;
        if (d == 0) return 1'b0;
        return ((k % (256 * div)) / div) >= d;
    endfunction

    function automatic logic [31:0] word(input logic en, input int rl, input int d);
        return {en, 15'b0, rl[7:0], d[7:0]};
    endfunction

    // Called just after a falling edge; returns at the falling edge after capture.
    task automatic write_word(input logic [31:0] w);
        wr_en   = 1'b1;
        wr_data = w;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Enables with (r1,d1); optionally writes (r2,d2) after sample chg_k.
    task automatic run_wave(input string tag, input int r1, input int d1, input int n,
                            input int chg_k, input int r2, input int d2);
        int div1, f;
        logic e;
        div1 = (r1 == 0) ? 256 : r1;
        f = (chg_k < 0) ? n + 1 : (chg_k / (256 * div1) + 1) * 256 * div1;
        write_word(word(1'b0, 0, 0));
        write_word(word(1'b1, r1, d1));
        for (int k = 0; k < n; k++) begin
            e = (k < f) ? exp_level(k, r1, d1) : exp_level(k - f, r2, d2);
            check(tag, {31'b0, pwm_out}, {31'b0, e});
            wr_en   = (k == chg_k);
            wr_data = word(1'b1, r2, d2);
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R2 readback after reset", rd_data, 32'h0);
        check("R2 output after reset", {31'b0, pwm_out}, 32'h0);
    endtask

    task automatic t_readback();
        write_word(32'h7FFF_0000);
        check("R1 reserved bits read zero", rd_data, 32'h0000_0000);
        check("R1 output stays off", {31'b0, pwm_out}, 32'h0);
        write_word(32'h8ABC_2345);
        check("R1 fields read back", rd_data, 32'h8000_2345);
        write_word(32'h0000_0000);
    endtask

    task automatic t_basic();
        run_wave("R5 R9 R4 reload1 duty128", 1, 128, 600, -1, 0, 0);
        run_wave("R5 reload1 duty255", 1, 255, 300, -1, 0, 0);
        run_wave("R5 reload1 duty1", 1, 1, 300, -1, 0, 0);
        run_wave("R3 R4 reload3 duty10", 3, 10, 1600, -1, 0, 0);
        run_wave("R3 reload0 divides by 256", 0, 1, 300, -1, 0, 0);
        run_wave("R6 duty0 stays low", 1, 0, 520, -1, 0, 0);
    endtask

    task automatic t_update();
        run_wave("R7 mid-frame write", 2, 40, 1100, 100, 1, 200);
        run_wave("R7 write at frame boundary", 1, 50, 520, 255, 1, 100);
    endtask

    task automatic t_disable();
        run_wave("R9 pre-disable run", 1, 5, 12, -1, 0, 0);
        check("R8 high before disable", {31'b0, pwm_out}, 32'h1);
        write_word(word(1'b0, 1, 5));
        check("R8 low after disable", {31'b0, pwm_out}, 32'h0);
        check("R8 readback after disable", rd_data, 32'h0000_0105);
        write_word(word(1'b1, 1, 5));
        for (int k = 0; k < 20; k++) begin
            check("R8 R9 restart at phase 0", {31'b0, pwm_out}, {31'b0, exp_level(k, 1, 5)});
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_basic();
        t_update();
        t_disable();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule